// File: doc/BRIEF.md
# Two-Channel DMA Controller

This block moves data in memory on behalf of a processor. It has two channels. Each channel holds a source address, a destination address, a 24-bit unit count and a 16-bit control word. A shared operation word carries the master enable and the arbitration mode. Software programs these through a simple register write port and reads them back through a combinational read port. A channel then copies units by issuing one read and then one write on a request/acknowledge memory master port. When a channel's count reaches zero, the controller sets the channel's transfer-end flag. If that channel has interrupts enabled, it also emits a one-cycle interrupt pulse that carries the channel's vector and a shared priority level.

A channel can run in two ways. In auto-request mode it moves units back to back until its count is exhausted. In external-request mode it moves one unit for each pulse on its request line. A 16-byte unit is carried out as four 32-bit read/write pairs. It uses up four counts, and its source always advances by 16.

Register map on `reg_addr`:

| Address | Contents |
|---|---|
| 0 to 3 | Channel 0 source, destination, count and control |
| 4 to 7 | The same four registers for channel 1 |
| 8 | Operation word: bit 0 is the master enable; bit 3 set selects round-robin, clear selects fixed priority |
| 9 | Interrupt setup: [6:0] is the channel 0 vector, [14:8] is the channel 1 vector, [19:16] is the level |

Other addresses read as zero.

Top module: `dma2ch`

## Requirements
- R1: After reset every register reads zero, `mem_req` and `irq_valid` are low.
- R2: Control word fields are: [15:14] destination step (2'b10 decrement, 2'b01 increment, else fixed), [13:12] source step (same coding), [11:10] unit size, bit 9 auto-request, bit 2 interrupt enable, bit 1 transfer end, bit 0 channel enable. A channel moves data only while master enable, its enable bit and a clear transfer-end bit all hold.
- R3: Size codes 0, 1, 2 give 1-, 2- and 4-byte units, each issued with `mem_size` equal to the code and consuming one count. Read data arrives right-justified on `mem_rdata`, and write data is driven right-justified on `mem_wdata`.
- R4: After each unit of size code 0 to 2, each address steps by the unit size according to its step field.
- R5: A size-3 unit issues four word read/write pairs at offsets 0, 4, 8 and 12 with `mem_size` 2. It takes 4 from the count (never going below zero), adds 16 to the source, and steps the destination by 16 according to its field.
- R6: Count writes keep only bits [23:0]; the upper bits read back as zero.
- R7: An auto-request channel moves units until its count is zero. A channel that starts with a zero count ends at once without bus traffic.
- R8: An external-request channel moves nothing without a pulse, and exactly one unit for each pulse on `dreq`.
- R9: When the count reaches zero the transfer-end bit sets. With interrupt enable set, `irq_valid` pulses for one cycle with that channel's vector and the level. With interrupt enable clear there is no pulse.
- R10: With both channels ready, fixed priority finishes channel 0 before channel 1 starts, while round-robin alternates units between them.
- R11: Writing 0 to the transfer-end bit clears it and writing 1 leaves it unchanged. A channel with transfer-end set stays idle.
- R12: Clearing master enable lets the unit in flight finish and starts no new one; addresses and count keep their values.
- R13: Each unit reads before it writes, and `mem_req` with its address and direction holds steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| dreq | input | 2 | External request pulses, one per channel |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge, completes the request |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| irq_valid | output | 1 | Interrupt pulse |
| irq_vec | output | 7 | Vector of the interrupting channel |
| irq_level | output | 4 | Interrupt level |

## Verification
A wrong address or count in a channel shows up within one unit, as a wrong `mem_addr` on the next read or as wrong readback at the register port. A broken beat counter in 16-byte mode shows up in the same unit, as misplaced offsets or a wrong number of word reads. A stuck transfer-end or pending-request flag shows up as a channel that keeps moving units after its count is exhausted, or as one that never starts. Either can be seen within a few dozen cycles as a count that stays frozen, or as an interrupt pulse that is missing or extra.

// File: rtl/dma2ch.sv
module dma2ch #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [1:0]        dreq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              irq_valid,
  output logic [6:0]        irq_vec,
  output logic [3:0]        irq_level
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t               st_q;
  logic [ADDR_W-1:0] src_q [2];
  logic [ADDR_W-1:0] dst_q [2];
  logic [CNT_W-1:0]  cnt_q [2];
  logic [15:0]       ctl_q [2];
  logic              me_q, rr_q, last_q, ch_q;
  logic [1:0]        pend_q, beat_q;
  logic [6:0]        vec0_q, vec1_q;
  logic [3:0]        lvl_q;
  logic [31:0]       buf_q;

  logic [1:0]        run;
  logic              pick;
  logic [1:0]        sz;
  logic [ADDR_W-1:0] step, src_nx, dst_nx;
  logic [CNT_W-1:0]  dec, cnt_nx;

  for (genvar c = 0; c < 2; c++) begin : g_run
    assign run[c] = me_q & ctl_q[c][0] & ~ctl_q[c][1] &
                    (ctl_q[c][9] | pend_q[c] | (cnt_q[c] == '0));
  end
  assign pick = (&run) ? (rr_q & ~last_q) : ~run[0];

  assign sz   = ctl_q[ch_q][11:10];
  assign step = (sz == 2'd3) ? ADDR_W'(16) : (ADDR_W'(1) << sz);
  assign dec  = (sz == 2'd3) ? CNT_W'(4) : CNT_W'(1);
  assign cnt_nx = (cnt_q[ch_q] > dec) ? cnt_q[ch_q] - dec : '0;

  always_comb begin
    case (ctl_q[ch_q][13:12])
      2'b10:   src_nx = src_q[ch_q] - step;
      2'b01:   src_nx = src_q[ch_q] + step;
      default: src_nx = src_q[ch_q];
    endcase
    if (sz == 2'd3) src_nx = src_q[ch_q] + step;
    case (ctl_q[ch_q][15:14])
      2'b10:   dst_nx = dst_q[ch_q] - step;
      2'b01:   dst_nx = dst_q[ch_q] + step;
      default: dst_nx = dst_q[ch_q];
    endcase
  end

  assign mem_req   = (st_q != S_IDLE);
  assign mem_we    = (st_q == S_WR);
  assign mem_addr  = ((st_q == S_WR) ? dst_q[ch_q] : src_q[ch_q]) + ADDR_W'({beat_q, 2'b00});
  assign mem_size  = (sz == 2'd3) ? 2'd2 : sz;
  assign mem_wdata = buf_q;

  always_comb begin
    case (reg_addr)
      4'd0: reg_rdata = 32'(src_q[0]);
      4'd1: reg_rdata = 32'(dst_q[0]);
      4'd2: reg_rdata = 32'(cnt_q[0]);
      4'd3: reg_rdata = {16'b0, ctl_q[0]};
      4'd4: reg_rdata = 32'(src_q[1]);
      4'd5: reg_rdata = 32'(dst_q[1]);
      4'd6: reg_rdata = 32'(cnt_q[1]);
      4'd7: reg_rdata = {16'b0, ctl_q[1]};
      4'd8: reg_rdata = {28'b0, rr_q, 2'b0, me_q};
      4'd9: reg_rdata = {12'b0, lvl_q, 1'b0, vec1_q, 1'b0, vec0_q};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      for (int c = 0; c < 2; c++) begin
        src_q[c] <= '0; dst_q[c] <= '0; cnt_q[c] <= '0; ctl_q[c] <= '0;
      end
      me_q <= 1'b0; rr_q <= 1'b0; last_q <= 1'b1; ch_q <= 1'b0;
      pend_q <= '0; beat_q <= '0; buf_q <= '0;
      vec0_q <= '0; vec1_q <= '0; lvl_q <= '0;
      irq_valid <= 1'b0; irq_vec <= '0; irq_level <= '0;
    end else begin
      irq_valid <= 1'b0;
      if (reg_we) begin
        case (reg_addr)
          4'd0: src_q[0] <= ADDR_W'(reg_wdata);
          4'd1: dst_q[0] <= ADDR_W'(reg_wdata);
          4'd2: cnt_q[0] <= reg_wdata[CNT_W-1:0];
          4'd3: ctl_q[0] <= {reg_wdata[15:2], ctl_q[0][1] & reg_wdata[1], reg_wdata[0]};
          4'd4: src_q[1] <= ADDR_W'(reg_wdata);
          4'd5: dst_q[1] <= ADDR_W'(reg_wdata);
          4'd6: cnt_q[1] <= reg_wdata[CNT_W-1:0];
          4'd7: ctl_q[1] <= {reg_wdata[15:2], ctl_q[1][1] & reg_wdata[1], reg_wdata[0]};
          4'd8: begin me_q <= reg_wdata[0]; rr_q <= reg_wdata[3]; end
          4'd9: begin vec0_q <= reg_wdata[6:0]; vec1_q <= reg_wdata[14:8]; lvl_q <= reg_wdata[19:16]; end
          default: ;
        endcase
      end
      for (int c = 0; c < 2; c++)
        if (dreq[c] && ctl_q[c][0] && !ctl_q[c][1]) pend_q[c] <= 1'b1;
      irq_level <= lvl_q;
      case (st_q)
        S_IDLE: if (|run) begin
          ch_q <= pick;
          last_q <= pick;
          pend_q[pick] <= 1'b0;
          beat_q <= '0;
          if (cnt_q[pick] == '0) begin
            ctl_q[pick][1] <= 1'b1;
            irq_valid <= ctl_q[pick][2];
            irq_vec <= pick ? vec1_q : vec0_q;
          end else st_q <= S_RD;
        end
        S_RD: if (mem_ack) begin
          buf_q <= mem_rdata;
          st_q <= S_WR;
        end
        S_WR: if (mem_ack) begin
          if (sz == 2'd3 && beat_q != 2'd3) begin
            beat_q <= beat_q + 2'd1;
            st_q <= S_RD;
          end else begin
            beat_q <= '0;
            src_q[ch_q] <= src_nx;
            dst_q[ch_q] <= dst_nx;
            cnt_q[ch_q] <= cnt_nx;
            if (cnt_nx == '0) begin
              ctl_q[ch_q][1] <= 1'b1;
              irq_valid <= ctl_q[ch_q][2];
              irq_vec <= ch_q ? vec1_q : vec0_q;
            end
            st_q <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  assert_me_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && !me_q) |=> !mem_req);
  assert_irq_has_te_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (ctl_q[0][1] || ctl_q[1][1]));
  assert_te0_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[0][1]) |-> (cnt_q[0] == '0));
  assert_te1_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[1][1]) |-> (cnt_q[1] == '0));
endmodule

// File: tb/dma2ch_tb.sv
`timescale 1ns/1ps
module dma2ch_tb;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [1:0] dreq = 0;
  logic mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic [1:0] mem_size;
  logic irq_valid;
  logic [6:0] irq_vec;
  logic [3:0] irq_level;

  int checks = 0, errors = 0;
  logic [7:0] mem [256];
  logic [31:0] rlog [16];
  int rn = 0, irq_cnt = 0;
  logic log_clr = 0;
  logic [1:0] last_size = 0;
  logic [6:0] got_vec = 0;
  logic [3:0] got_lvl = 0;

  always #2.5 clk = ~clk;

  dma2ch u_dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq_valid(irq_valid),
    .irq_vec(irq_vec), .irq_level(irq_level));

  always @(posedge clk) begin
    if (log_clr) rn <= 0;
    if (irq_valid) begin irq_cnt <= irq_cnt + 1; got_vec <= irq_vec; got_lvl <= irq_level; end
    if (mem_req && !mem_ack) begin
      mem_ack <= 1;
      last_size <= mem_size;
      if (mem_we) begin
        mem[mem_addr[7:0]] = mem_wdata[7:0];
        if (mem_size >= 1) mem[8'(mem_addr[7:0] + 1)] = mem_wdata[15:8];
        if (mem_size == 2) begin
          mem[8'(mem_addr[7:0] + 2)] = mem_wdata[23:16];
          mem[8'(mem_addr[7:0] + 3)] = mem_wdata[31:24];
        end
      end else begin
        if (!log_clr && rn < 16) begin rlog[rn] <= mem_addr; rn <= rn + 1; end
        case (mem_size)
          2'd0: mem_rdata <= {24'b0, mem[mem_addr[7:0]]};
          2'd1: mem_rdata <= {16'b0, mem[8'(mem_addr[7:0] + 1)], mem[mem_addr[7:0]]};
          default: mem_rdata <= {mem[8'(mem_addr[7:0] + 3)], mem[8'(mem_addr[7:0] + 2)],
                                 mem[8'(mem_addr[7:0] + 1)], mem[mem_addr[7:0]]};
        endcase
      end
    end else mem_ack <= 0;
  end

  function automatic logic [31:0] w32(int a);
    return {mem[8'(a + 3)], mem[8'(a + 2)], mem[8'(a + 1)], mem[8'(a)]};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); reg_addr = 4'(a); #1; d = reg_rdata;
  endtask

  task automatic clr_log();
    @(negedge clk); log_clr = 1; @(negedge clk); log_clr = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 10; a++) begin
      rd(a, d);
      chk(d == 0, "R1 reg", d, 0);
    end
    chk(!mem_req && !irq_valid, "R1 idle", {mem_req, irq_valid}, 0);
  endtask

  task automatic t_byte_auto();
    logic [31:0] d;
    int i0;
    i0 = irq_cnt;
    wr(9, 32'h0009_2A15);
    wr(0, 32'h00); wr(1, 32'h20); wr(2, 32'h7F00_0003);
    rd(2, d); chk(d == 3, "R6 count mask", d, 3);
    wr(3, 32'h5205);
    chk(!mem_req, "R2 no run without master enable", mem_req, 0);
    wr(8, 1);
    repeat (60) @(negedge clk);
    for (int i = 0; i < 3; i++) chk(mem[8'(32 + i)] == mem[8'(i)], "R3 byte copy", mem[8'(32 + i)], mem[8'(i)]);
    rd(0, d); chk(d == 3, "R4 src inc", d, 3);
    rd(1, d); chk(d == 32'h23, "R4 dst inc", d, 32'h23);
    rd(2, d); chk(d == 0, "R7 count zero", d, 0);
    rd(3, d); chk(d[1], "R9 te set", d, 1);
    chk(irq_cnt == i0 + 1 && got_vec == 7'h15 && got_lvl == 4'h9, "R9 irq",
        {irq_cnt[15:0], 5'b0, got_vec, got_lvl}, {16'(i0 + 1), 5'b0, 7'h15, 4'h9});
  endtask

  task automatic t_restart();
    logic [31:0] d;
    wr(2, 1); wr(3, 32'h5207);
    repeat (30) @(negedge clk);
    rd(2, d); chk(d == 1, "R11 te held blocks run", d, 1);
    rd(3, d); chk(d[1], "R11 write 1 keeps te", d, 1);
    wr(3, 32'h5205);
    repeat (30) @(negedge clk);
    rd(2, d); chk(d == 0, "R11 restart after clear", d, 0);
    wr(3, 0);
  endtask

  task automatic t_words();
    logic [31:0] d, e;
    e = w32(32'h80);
    wr(0, 32'h80); wr(1, 32'hC0); wr(2, 2);
    clr_log();
    wr(3, 32'h8A01);
    repeat (40) @(negedge clk);
    chk(last_size == 2, "R3 word size", last_size, 2);
    chk(w32(32'hBC) == e && w32(32'hC0) == e, "R4 fixed src copy", w32(32'hBC), e);
    rd(0, d); chk(d == 32'h80, "R4 src fixed", d, 32'h80);
    rd(1, d); chk(d == 32'hB8, "R4 dst dec", d, 32'hB8);
    wr(3, 0);
    wr(0, 32'h10); wr(1, 32'h30); wr(2, 2);
    wr(3, 32'h5601);
    repeat (40) @(negedge clk);
    chk(last_size == 1, "R3 half size", last_size, 1);
    chk({mem[8'h33], mem[8'h32]} == {mem[8'h13], mem[8'h12]}, "R3 half copy",
        {mem[8'h33], mem[8'h32]}, {mem[8'h13], mem[8'h12]});
    rd(0, d); chk(d == 32'h14, "R4 src inc half", d, 32'h14);
    wr(3, 0);
  endtask

  task automatic t_burst();
    logic [31:0] d, e;
    e = w32(32'h9C);
    wr(0, 32'h80); wr(1, 32'hE0); wr(2, 8);
    clr_log();
    wr(3, 32'h0E01);
    repeat (100) @(negedge clk);
    chk(rn == 8, "R5 eight word reads", rn, 8);
    for (int i = 0; i < 4; i++) chk(rlog[i] == 32'h80 + 4 * i, "R5 offsets", rlog[i], 32'h80 + 4 * i);
    chk(w32(32'hEC) == e, "R5 last beat data", w32(32'hEC), e);
    rd(0, d); chk(d == 32'hA0, "R5 src +16 always", d, 32'hA0);
    rd(1, d); chk(d == 32'hE0, "R5 dst fixed", d, 32'hE0);
    rd(2, d); chk(d == 0, "R5 count", d, 0);
    wr(3, 0);
  endtask

  task automatic t_dreq();
    logic [31:0] d;
    int i0;
    i0 = irq_cnt;
    wr(4, 32'h50); wr(5, 32'h70); wr(6, 2); wr(7, 32'h5001);
    repeat (30) @(negedge clk);
    rd(6, d); chk(d == 2, "R8 no pulse no move", d, 2);
    for (int k = 1; k >= 0; k--) begin
      @(negedge clk); dreq = 2'b10; @(negedge clk); dreq = 0;
      repeat (30) @(negedge clk);
      rd(6, d); chk(d == 32'(k), "R8 one unit per pulse", d, 32'(k));
    end
    rd(7, d); chk(d[1], "R9 te on dreq channel", d, 1);
    chk(irq_cnt == i0, "R9 no irq when disabled", irq_cnt, i0);
    wr(7, 0);
  endtask

  task automatic t_me_stop();
    logic [31:0] a, b, s;
    wr(0, 32'h00); wr(1, 32'h40); wr(2, 40); wr(3, 32'h5201);
    repeat (30) @(negedge clk);
    wr(8, 0);
    repeat (20) @(negedge clk);
    rd(2, a);
    repeat (40) @(negedge clk);
    rd(2, b);
    chk(a == b && a > 0 && a < 40, "R12 stops and holds", b, a);
    rd(0, s); chk(s == 40 - a, "R12 src consistent", s, 40 - a);
    chk(!mem_req, "R12 bus idle", mem_req, 0);
    wr(3, 0);
  endtask

  task automatic t_prio(bit rr);
    wr(0, 32'h00); wr(1, 32'h20); wr(2, 2); wr(3, 32'h5201);
    wr(4, 32'h40); wr(5, 32'h60); wr(6, 2); wr(7, 32'h5201);
    clr_log();
    wr(8, rr ? 32'h9 : 32'h1);
    repeat (60) @(negedge clk);
    chk(rn == 4, "R10 four reads", rn, 4);
    if (rr) begin
      for (int i = 0; i < 3; i++)
        chk(rlog[i][6] != rlog[i + 1][6], "R10 round robin alternates", rlog[i + 1], rlog[i]);
    end else begin
      chk(rlog[0] == 0 && rlog[1] == 1 && rlog[2] == 32'h40 && rlog[3] == 32'h41,
          "R10 fixed order", {rlog[1][7:0], rlog[2][7:0]}, 16'h0140);
    end
    wr(8, 0); wr(3, 0); wr(7, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_byte_auto();
    t_restart();
    t_words();
    t_burst();
    t_dreq();
    wr(8, 1);
    t_me_stop();
    t_prio(0);
    t_prio(1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule